// File: doc/BRIEF.md
# Calibration Retention Store with Indirect Access and Replay

This block holds radio calibration words for three receive chains and can push them back to the radio settings on command. Each chain owns a six-entry table of 28-bit words. Entries 0, 1 and 2 hold DC offset values (loop, low and high), entry 3 the filter cutoff setting, entry 4 the receive gain setting and entry 5 the peak detector offset. Software never addresses the table directly. It goes through two registers per chain: a data register, and an access control register that holds an entry index, a direction bit and a self-clearing busy bit.

A global register holds an enable bit, a six-bit replay mask and a self-clearing replay command. A replay walks chain 0 to chain 2, and within each chain entries 0 to 5, at one entry per cycle. Each entry whose mask bit is set is copied onto its own output word, and that chain's update strobe pulses in the same cycle. The outputs model radio settings that are always accepted, so the update strobe is a valid with no ready and there is no back-pressure. The register bus has no stall either: a write is taken in the cycle it is presented, and reads are combinational.

Register map (reg_addr): 0 global, 1 + 2c access control of chain c, 2 + 2c data of chain c; address 7 reads 0. Global: bit 0 enable, bits 9:4 mask (bit 4 + e selects entry e), bit 16 replay busy/command. Access control: bits 2:0 entry index, bit 4 direction (1 = store to table, 0 = load from table), bit 8 busy/start. Data: bits 27:0.

Top module: `cal_retention_ctrl`

## Requirements
- R1: After reset every register field, every table entry, every radio_word bit and radio_upd read 0.
- R2: A write to a chain's access control register with bit 8 = 1 and bit 4 = 1 stores that chain's data register into the entry given by bits 2:0 when the transaction completes.
- R3: With bit 4 = 0 the transaction copies the addressed entry into the chain's data register, readable at 2 + 2c.
- R4: Bit 8 of the access control register reads 1 for exactly 4 cycles after the cycle the start write is taken, then reads 0.
- R5: While bit 8 reads 1, writes to that chain's access control and data registers are ignored.
- R6: An entry index of 6 or 7 stores nothing, and a load from it puts 0 in the data register.
- R7: A global write with bit 16 = 1 but bit 0 = 0 starts no replay: bit 16 reads 0 and radio_word does not change.
- R8: A global write with bits 0 and 16 set starts a replay. Bit 16 then reads 1 for 18 cycles, and one table position is visited per cycle, chain-major and in ascending order.
- R9: During a replay only entries with their mask bit set update radio_word (chain c, entry e at bits (6c+e)*28 +: 28). radio_upd[c] pulses for exactly the cycles in which chain c is updated, and other output words hold.
- R10: Global writes issued while bit 16 reads 1 are ignored entirely, leaving the enable, the mask and the running replay unchanged.
- R11: Each chain's access sequencer is independent, so a chain accepts a start while another chain is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| radio_word | output | 504 | Replayed words, chain c entry e at (6c+e)*28 |
| radio_upd | output | 3 | Per-chain update strobe, one cycle per updated entry |

## Verification
Table transactions are tried as stores and loads on every chain, as starts overlapping a busy transaction, with out-of-range indices, and with a second chain started while the first is busy. These patterns separate correct indexing and completion timing from ignored or cross-chain effects. Replays are run with a full mask, with a sparse mask after the tables change, with enable low, and with a global write arriving mid-replay. Comparing every output on every cycle against a behavioural model then exposes any error in the walk order, the masking, the strobe timing or the guard on the command.

// File: rtl/cal_ret_pkg.sv
package cal_ret_pkg;
  localparam int REG_W        = 32;
  localparam int GC_EN_BIT    = 0;
  localparam int GC_MASK_LSB  = 4;
  localparam int GC_FORCE_BIT = 16;
  localparam int CC_WSEL_BIT  = 4;
  localparam int CC_ACC_BIT   = 8;
endpackage

// File: rtl/cal_ret_chain.sv
module cal_ret_chain
  import cal_ret_pkg::*;
#(
  parameter int NUM_CHAINS  = 3,
  parameter int NUM_ENTRIES = 6,
  parameter int DATA_W      = 28,
  parameter int ACC_CYCLES  = 4,
  parameter int CHAIN_ID    = 0,
  localparam int EW   = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CW   = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1,
  localparam int CNTW = $clog2(ACC_CYCLES + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctrl_we,
  input  logic                          data_we,
  input  logic [EW-1:0]                 wd_addr,
  input  logic                          wd_wsel,
  input  logic                          wd_acc,
  input  logic [DATA_W-1:0]             wd_data,
  input  logic                          step_act,
  input  logic [CW-1:0]                 step_chain,
  input  logic [EW-1:0]                 step_entry,
  input  logic [NUM_ENTRIES-1:0]        mask,
  output logic [REG_W-1:0]              ctrl_rd,
  output logic [REG_W-1:0]              data_rd,
  output logic [NUM_ENTRIES*DATA_W-1:0] out_flat,
  output logic                          upd
);
  logic [EW-1:0]     addr_q;
  logic              wsel_q;
  logic              busy_q;
  logic [CNTW-1:0]   cnt_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] tbl_q [NUM_ENTRIES];
  logic [DATA_W-1:0] out_q [NUM_ENTRIES];
  logic              upd_q;
  logic              done;
  logic              in_range;
  logic [DATA_W-1:0] rd_word;
  logic [NUM_ENTRIES-1:0] step_sel;

  assign done     = busy_q && (cnt_q == '0);
  assign in_range = ({1'b0, addr_q} < (EW+1)'(NUM_ENTRIES));

  always_comb begin
    rd_word = '0;
    for (int e = 0; e < NUM_ENTRIES; e++)
      if (addr_q == EW'(e)) rd_word = tbl_q[e];
  end

  always_comb begin
    for (int e = 0; e < NUM_ENTRIES; e++)
      step_sel[e] = step_act && (step_chain == CW'(CHAIN_ID)) &&
                    (step_entry == EW'(e)) && mask[e];
  end

  // access sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wsel_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        if (!wsel_q) data_q <= in_range ? rd_word : '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      if (ctrl_we) begin
        addr_q <= wd_addr;
        wsel_q <= wd_wsel;
        if (wd_acc) begin
          busy_q <= 1'b1;
          cnt_q  <= CNTW'(ACC_CYCLES - 1);
        end
      end
      if (data_we) data_q <= wd_data;
    end
  end

  // table storage and replay outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        tbl_q[e] <= '0;
        out_q[e] <= '0;
      end
      upd_q <= 1'b0;
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (done && wsel_q && (addr_q == EW'(e))) tbl_q[e] <= data_q;
        if (step_sel[e]) out_q[e] <= tbl_q[e];
      end
      upd_q <= |step_sel;
    end
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_out
    assign out_flat[e*DATA_W +: DATA_W] = out_q[e];
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[EW-1:0]    = addr_q;
    ctrl_rd[CC_WSEL_BIT] = wsel_q;
    ctrl_rd[CC_ACC_BIT]  = busy_q;
  end
  assign data_rd = {{(REG_W-DATA_W){1'b0}}, data_q};
  assign upd     = upd_q;

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (cnt_q != '0) |=> busy_q); // R4
  AST_ACC_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == '0)); // R4
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && ctrl_we |=> $stable(addr_q) && $stable(wsel_q)); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(|step_sel) |=> $stable(out_flat)); // R9
  AST_UPD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> $past(step_act)); // R8
endmodule

// File: rtl/cal_ret_restore.sv
module cal_ret_restore
#(
  parameter int NUM_CHAINS  = 3,
  parameter int NUM_ENTRIES = 6,
  localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CW = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   glob_we,
  input  logic                   wd_en,
  input  logic                   wd_force,
  input  logic [NUM_ENTRIES-1:0] wd_mask,
  output logic                   enable,
  output logic [NUM_ENTRIES-1:0] mask,
  output logic                   active,
  output logic [CW-1:0]          step_chain,
  output logic [EW-1:0]          step_entry
);
  logic                   en_q;
  logic                   act_q;
  logic [NUM_ENTRIES-1:0] mask_q;
  logic [CW-1:0]          ch_q;
  logic [EW-1:0]          ent_q;
  logic                   last_ent;
  logic                   last_ch;

  assign last_ent = (ent_q == EW'(NUM_ENTRIES - 1));
  assign last_ch  = (ch_q == CW'(NUM_CHAINS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      mask_q <= '0;
      ch_q   <= '0;
      ent_q  <= '0;
    end else if (act_q) begin
      if (last_ent) begin
        ent_q <= '0;
        if (last_ch) begin
          act_q <= 1'b0;
          ch_q  <= '0;
        end else begin
          ch_q <= ch_q + 1'b1;
        end
      end else begin
        ent_q <= ent_q + 1'b1;
      end
    end else if (glob_we) begin
      en_q   <= wd_en;
      mask_q <= wd_mask;
      if (wd_en && wd_force) act_q <= 1'b1;
    end
  end

  assign enable     = en_q;
  assign mask       = mask_q;
  assign active     = act_q;
  assign step_chain = ch_q;
  assign step_entry = ent_q;

  AST_FORCE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> en_q); // R7
  AST_CMD_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && glob_we |=> $stable(mask_q) && $stable(en_q)); // R10
  AST_WALK_ON: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !(last_ent && last_ch) |=> act_q); // R8
  AST_WALK_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> (ch_q == '0) && (ent_q == '0)); // R8
endmodule

// File: rtl/cal_retention_ctrl.sv
module cal_retention_ctrl
  import cal_ret_pkg::*;
#(
  parameter int NUM_CHAINS  = 3,
  parameter int NUM_ENTRIES = 6,
  parameter int DATA_W      = 28,
  parameter int ACC_CYCLES  = 4,
  localparam int AW = $clog2(2*NUM_CHAINS + 1),
  localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CW = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     reg_we,
  input  logic [AW-1:0]                            reg_addr,
  input  logic [REG_W-1:0]                         reg_wdata,
  output logic [REG_W-1:0]                         reg_rdata,
  output logic [NUM_CHAINS*NUM_ENTRIES*DATA_W-1:0] radio_word,
  output logic [NUM_CHAINS-1:0]                    radio_upd
);
  logic                   enable;
  logic [NUM_ENTRIES-1:0] mask;
  logic                   active;
  logic [CW-1:0]          step_chain;
  logic [EW-1:0]          step_entry;
  logic [REG_W-1:0]       ctrl_rd [NUM_CHAINS];
  logic [REG_W-1:0]       data_rd [NUM_CHAINS];
  logic                   unused_wdata;

  assign unused_wdata = ^reg_wdata;

  cal_ret_restore #(
    .NUM_CHAINS (NUM_CHAINS),
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_restore (
    .clk       (clk),
    .rst_n     (rst_n),
    .glob_we   (reg_we && (reg_addr == '0)),
    .wd_en     (reg_wdata[GC_EN_BIT]),
    .wd_force  (reg_wdata[GC_FORCE_BIT]),
    .wd_mask   (reg_wdata[GC_MASK_LSB +: NUM_ENTRIES]),
    .enable    (enable),
    .mask      (mask),
    .active    (active),
    .step_chain(step_chain),
    .step_entry(step_entry)
  );

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    cal_ret_chain #(
      .NUM_CHAINS (NUM_CHAINS),
      .NUM_ENTRIES(NUM_ENTRIES),
      .DATA_W     (DATA_W),
      .ACC_CYCLES (ACC_CYCLES),
      .CHAIN_ID   (c)
    ) u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (reg_we && (reg_addr == AW'(1 + 2*c))),
      .data_we   (reg_we && (reg_addr == AW'(2 + 2*c))),
      .wd_addr   (reg_wdata[EW-1:0]),
      .wd_wsel   (reg_wdata[CC_WSEL_BIT]),
      .wd_acc    (reg_wdata[CC_ACC_BIT]),
      .wd_data   (reg_wdata[DATA_W-1:0]),
      .step_act  (active),
      .step_chain(step_chain),
      .step_entry(step_entry),
      .mask      (mask),
      .ctrl_rd   (ctrl_rd[c]),
      .data_rd   (data_rd[c]),
      .out_flat  (radio_word[c*NUM_ENTRIES*DATA_W +: NUM_ENTRIES*DATA_W]),
      .upd       (radio_upd[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) begin
      reg_rdata[GC_EN_BIT]                   = enable;
      reg_rdata[GC_MASK_LSB +: NUM_ENTRIES]  = mask;
      reg_rdata[GC_FORCE_BIT]                = active;
    end
    for (int c = 0; c < NUM_CHAINS; c++) begin
      if (reg_addr == AW'(1 + 2*c)) reg_rdata = ctrl_rd[c];
      if (reg_addr == AW'(2 + 2*c)) reg_rdata = data_rd[c];
    end
  end

  AST_UPD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(radio_upd)); // R9
  AST_UPD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (radio_upd != '0) |-> $past(active) && $past(mask[step_entry])); // R9
endmodule

// File: tb/tb_cal_retention_ctrl.sv
`timescale 1ns/1ps
module tb_cal_retention_ctrl;
  localparam int NC = 3;
  localparam int NE = 6;
  localparam int DW = 28;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [NC*NE*DW-1:0] radio_word;
  logic [NC-1:0] radio_upd;

  int checks = 0;
  int errors = 0;
  string phase = "R1 reset";
  bit finished = 0;

  always #10 clk = ~clk;

  cal_retention_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .radio_word(radio_word), .radio_upd(radio_upd)
  );

  // behavioural reference model
  int          m_rem  [NC];
  logic [2:0]  m_addr [NC];
  bit          m_wsel [NC];
  logic [27:0] m_data [NC];
  logic [27:0] m_tbl  [NC][NE];
  logic [27:0] m_out  [NC][NE];
  bit          m_upd  [NC];
  bit          m_en, m_act;
  logic [5:0]  m_mask;
  int          m_pos;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_rem[c] <= 0; m_addr[c] <= 0; m_wsel[c] <= 0; m_data[c] <= 0; m_upd[c] <= 0;
        for (int e = 0; e < NE; e++) begin m_tbl[c][e] <= 0; m_out[c][e] <= 0; end
      end
      m_en <= 0; m_act <= 0; m_mask <= 0; m_pos <= 0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        m_upd[c] <= 0;
        if (m_rem[c] > 0) begin
          if (m_rem[c] == 1) begin
            if (m_wsel[c]) begin
              if (m_addr[c] < 6) m_tbl[c][m_addr[c]] <= m_data[c];
            end else begin
              m_data[c] <= (m_addr[c] < 6) ? m_tbl[c][m_addr[c]] : 28'd0;
            end
          end
          m_rem[c] <= m_rem[c] - 1;
        end else if (reg_we && reg_addr == 3'(1 + 2*c)) begin
          m_addr[c] <= reg_wdata[2:0];
          m_wsel[c] <= reg_wdata[4];
          if (reg_wdata[8]) m_rem[c] <= 4;
        end else if (reg_we && reg_addr == 3'(2 + 2*c)) begin
          m_data[c] <= reg_wdata[27:0];
        end
      end
      if (m_act) begin
        if (m_mask[m_pos % NE]) begin
          m_out[m_pos / NE][m_pos % NE] <= m_tbl[m_pos / NE][m_pos % NE];
          m_upd[m_pos / NE] <= 1;
        end
        if (m_pos == NC*NE - 1) begin m_act <= 0; m_pos <= 0; end
        else m_pos <= m_pos + 1;
      end else if (reg_we && reg_addr == 3'd0) begin
        m_en   <= reg_wdata[0];
        m_mask <= reg_wdata[9:4];
        if (reg_wdata[0] && reg_wdata[16]) begin m_act <= 1; m_pos <= 0; end
      end
    end
  end

  function automatic logic [31:0] m_rd(input logic [2:0] a);
    logic [31:0] r;
    r = 0;
    if (a == 0) begin r[0] = m_en; r[9:4] = m_mask; r[16] = m_act; end
    for (int c = 0; c < NC; c++) begin
      if (a == 3'(1 + 2*c)) begin r[2:0] = m_addr[c]; r[4] = m_wsel[c]; r[8] = (m_rem[c] != 0); end
      if (a == 3'(2 + 2*c)) r[27:0] = m_data[c];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    logic [NC*NE*DW-1:0] ew;
    logic [NC-1:0] eu;
    for (int c = 0; c < NC; c++) begin
      eu[c] = m_upd[c];
      for (int e = 0; e < NE; e++) ew[(c*NE+e)*DW +: DW] = m_out[c][e];
    end
    chk({phase, " rdata"}, 512'(reg_rdata), 512'(m_rd(reg_addr)));
    chk({phase, " radio_word"}, 512'(radio_word), 512'(ew));
    chk({phase, " radio_upd"}, 512'(radio_upd), 512'(eu));
  end

  function automatic logic [27:0] pat(input int c, input int e);
    return 28'h0100000 * (c + 1) + 28'h0000100 * (e + 3) + 28'(c * 7 + e);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic wait_idle(input int c);
    reg_addr = 3'(1 + 2*c);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!reg_rdata[8]) break;
    end
  endtask

  task automatic tbl_write(input int c, input int e, input logic [27:0] v);
    wr(3'(2 + 2*c), 32'(v));
    wr(3'(1 + 2*c), 32'h110 | 32'(e));
    wait_idle(c);
  endtask

  task automatic tbl_read(input int c, input int e, output logic [31:0] v);
    wr(3'(1 + 2*c), 32'h100 | 32'(e));
    wait_idle(c);
    reg_addr = 3'(2 + 2*c);
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic run_restore(input logic [5:0] msk, output int busy_cycles, output int pulses);
    wr(3'd0, 32'h10001 | (32'(msk) << 4));
    reg_addr = 3'd0;
    busy_cycles = 0; pulses = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (reg_rdata[16]) busy_cycles++;
      pulses += $countones(radio_upd);
    end
  endtask

  initial begin
    logic [31:0] v;
    int n, p;
    reg_we = 0; reg_addr = 0; reg_wdata = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 global reg", 512'(reg_rdata), 512'(0));
    chk("R1 radio_word", 512'(radio_word), 512'(0));
    chk("R1 radio_upd", 512'(radio_upd), 512'(0));

    phase = "R2 table stores";
    for (int c = 0; c < NC; c++)
      for (int e = 0; e < NE; e++) tbl_write(c, e, pat(c, e));

    phase = "R4 access timing";
    wr(3'd1, 32'h100);
    reg_addr = 3'd1; n = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (reg_rdata[8]) n++; end
    chk("R4 busy cycles", 512'(n), 512'(4));

    phase = "R5 busy ignore";
    wr(3'd2, 32'h0AAAAAA);
    wr(3'd1, 32'h111);
    wr(3'd2, 32'h0555555);
    wr(3'd1, 32'h105);
    wait_idle(0);
    chk("R5 ctrl unchanged", 512'(reg_rdata), 512'(32'h011));
    tbl_read(0, 1, v);
    chk("R5 entry kept first data", 512'(v), 512'(32'h0AAAAAA));

    phase = "R3 loads";
    tbl_read(1, 3, v);
    chk("R3 chain1 entry3", 512'(v), 512'(pat(1, 3)));
    tbl_read(2, 5, v);
    chk("R3 chain2 entry5", 512'(v), 512'(pat(2, 5)));

    phase = "R6 out of range";
    wr(3'd6, 32'h0005555);
    wr(3'd5, 32'h116);
    wait_idle(2);
    tbl_read(2, 7, v);
    chk("R6 load index 7", 512'(v), 512'(0));

    phase = "R11 independent chains";
    wr(3'd1, 32'h100);
    wr(3'd3, 32'h100);
    reg_addr = 3'd3;
    @(negedge clk);
    chk("R11 chain1 accepted", 512'(reg_rdata[8]), 512'(1));
    wait_idle(0);
    wait_idle(1);

    phase = "R7 force without enable";
    wr(3'd0, 32'h103F0);
    reg_addr = 3'd0;
    @(negedge clk);
    chk("R7 global read", 512'(reg_rdata), 512'(32'h3F0));
    repeat (25) @(negedge clk);
    chk("R7 outputs idle", 512'(radio_word), 512'(0));

    phase = "R8 full replay";
    run_restore(6'h3F, n, p);
    chk("R8 busy cycles", 512'(n), 512'(18));
    chk("R8 pulses", 512'(p), 512'(18));
    chk("R8 chain0 entry1", 512'(radio_word[1*DW +: DW]), 512'(28'h0AAAAAA));
    chk("R8 chain2 entry4", 512'(radio_word[(2*NE+4)*DW +: DW]), 512'(pat(2, 4)));

    phase = "R10 command guard";
    wr(3'd0, 32'h103F1);
    wr(3'd0, 32'h00011);
    reg_addr = 3'd0;
    repeat (25) @(negedge clk);
    chk("R10 global unchanged", 512'(reg_rdata), 512'(32'h3F1));

    phase = "R9 sparse mask";
    tbl_write(1, 0, 28'h0C0FFEE);
    tbl_write(1, 2, 28'h0D00D00);
    tbl_write(1, 5, 28'h0BEEF05);
    run_restore(6'h21, n, p);
    chk("R9 pulses", 512'(p), 512'(6));
    chk("R9 chain1 entry0", 512'(radio_word[(NE+0)*DW +: DW]), 512'(28'h0C0FFEE));
    chk("R9 chain1 entry5", 512'(radio_word[(NE+5)*DW +: DW]), 512'(28'h0BEEF05));
    chk("R9 chain1 entry2 held", 512'(radio_word[(NE+2)*DW +: DW]), 512'(pat(1, 2)));

    phase = "R2 final";
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule